// File: doc/BRIEF.md
# Processor Interrupt Entry Controller

This block decides when a small 32-bit core enters an exception handler. It watches a reset request, one non-maskable interrupt line and six maskable request lines. When a request is accepted, it issues a redirect strobe that lasts one cycle and carries the new program counter. In the same cycle it updates its copy of the program status word (PSW) and the exception cause register, and it saves the interrupted PC and PSW so the handler can return.

Each request line is caught in a pending latch, so a pulse one cycle wide is enough. The latch holds the request until the controller accepts it. The controller keeps two separate save areas, one for the non-maskable interrupt and one for the maskable interrupts, so a non-maskable interrupt can arrive inside a maskable handler without losing the outer context. The core leaves a handler with a return strobe and a select bit that picks which save area is restored. The core can also load the PSW copy directly when it changes the PSW by its own means.

Top module: `irq_entry_ctrl`

## Requirements
- R1: A reset request redirects to PC 0 on the next cycle, with PSW = 0x20 and cause = 0, and kind code 0. It discards every pending request, including any that arrive in the same cycle.
- R2: A non-maskable request that arrives while the NMI-active bit (PSW bit 7) is set is kept and delivered once that bit is clear. Several such arrivals collapse into one delivery.
- R3: Non-maskable entry copies the current PC and PSW into the non-maskable save registers and leaves the maskable save registers unchanged.
- R4: Non-maskable entry sets PSW bit 7 (NMI-active) and bit 5 (disable), clears bit 6 (exception-processing), and redirects to 0x10 with kind code 1.
- R5: Non-maskable entry writes 0x10 into cause bits 31:16 and leaves cause bits 15:0 unchanged.
- R6: No maskable request is accepted while PSW bit 7 or bit 5 is set. Such a request stays pending until it can be taken.
- R7: Maskable entry copies PC and PSW into the maskable save registers, sets PSW bit 5, clears bit 6, loads cause bits 15:0 with the source code, keeps cause bits 31:16, and uses kind code 2.
- R8: Maskable source i (0 to 5) redirects to 0x80 + 0x10*i, and its cause code equals that address.
- R9: A non-maskable request that arrives in the same cycle as a non-maskable acceptance stays pending and is delivered after the active bit clears.
- R10: A pending non-maskable request beats every maskable one. Among maskable requests, the lowest source index wins. Each pending latch clears only when its own source is accepted.
- R11: A return strobe redirects on the next cycle to the saved PC, restores the saved PSW, and uses kind code 3. The select input chooses the non-maskable save area when it is 1 and the maskable save area when it is 0. No request is accepted in that cycle.
- R12: The redirect strobe is high for a single cycle. A request sampled at one clock edge produces its redirect at the following edge.
- R13: A PSW load strobe replaces the PSW copy on the next edge. No request is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_req | input | 1 | Reset request from the core |
| nmi_req | input | 1 | Non-maskable request |
| mi_req | input | 6 | Maskable request lines, bit i is source i |
| cur_pc | input | 32 | PC of the interrupted instruction |
| ret_strobe | input | 1 | Return from handler |
| ret_sel | input | 1 | 1 restores the non-maskable save area, 0 the maskable one |
| psw_wr_en | input | 1 | Load the PSW copy |
| psw_wr_data | input | 32 | Value for the PSW load |
| redirect | output | 1 | One-cycle redirect strobe |
| redirect_pc | output | 32 | Target PC of the redirect |
| redirect_kind | output | 2 | 0 reset, 1 non-maskable, 2 maskable, 3 return |
| psw | output | 32 | Current PSW copy |
| ecr | output | 32 | Exception cause register |
| nmi_save_pc | output | 32 | Saved PC for the non-maskable interrupt |
| nmi_save_psw | output | 32 | Saved PSW for the non-maskable interrupt |
| mi_save_pc | output | 32 | Saved PC for maskable interrupts |
| mi_save_psw | output | 32 | Saved PSW for maskable interrupts |

## Verification
The assertions check on every cycle how each redirect relates to the state before it. This covers the reset values, the PSW bits and cause halves written on both kinds of entry, the save-register copies, the fact that a maskable entry never follows a cycle with bit 7 or bit 5 set, and the target and PSW restored on a return. Only the bench scenarios can show what pending storage does over time: non-maskable requests collapsing into one delivery, a request that arrives during acceptance being delivered later, the exhaustive sweep of the priority order over all 63 source combinations, and the reset request discarding held requests.

// File: rtl/irq_entry_pkg.sv
// Package: shared constants and types for the interrupt entry controller.
// Assumes a 32-bit PSW whose control bits sit at the positions given here.
package irq_entry_pkg;
    localparam int XLEN       = 32;
    localparam int PSW_NP_BIT = 7;   // NMI-active
    localparam int PSW_EP_BIT = 6;   // exception-processing
    localparam int PSW_ID_BIT = 5;   // interrupt disable

    localparam logic [XLEN-1:0] PSW_AT_RESET = 32'h0000_0020;
    localparam logic [XLEN-1:0] NMI_TARGET   = 32'h0000_0010;

    typedef enum logic [1:0] {
        RK_RESET  = 2'd0,
        RK_NMI    = 2'd1,
        RK_MASK   = 2'd2,
        RK_RETURN = 2'd3
    } redir_kind_e;
endpackage

// File: rtl/irq_pend_latch.sv
// Module: pending latches, one for the NMI and one per maskable source.
// A latch sets when its request is high and clears only when its own
// source is taken. A clear-all input discards everything, including
// requests that arrive in the same cycle.
module irq_pend_latch #(
    parameter int N_MI = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_all,
    input  logic            nmi_req,
    input  logic [N_MI-1:0] mi_req,
    input  logic            nmi_take,
    input  logic [N_MI-1:0] mi_take,
    output logic            nmi_pend,
    output logic [N_MI-1:0] mi_pend
);

    // Single NMI slot: new arrivals merge into it and are not counted.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            nmi_pend <= 1'b0;
        end else begin
            nmi_pend <= (nmi_pend & ~nmi_take) | nmi_req;
        end
    end

    generate
        for (genvar g = 0; g < N_MI; g++) begin : g_src
            // Per-source latch: set on request, clear on own acceptance.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_all) begin
                    mi_pend[g] <= 1'b0;
                end else begin
                    mi_pend[g] <= (mi_pend[g] & ~mi_take[g]) | mi_req[g];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/irq_arbiter.sv
// Module: decides which pending request is accepted this cycle.
// NMI first, unless the NMI-active bit is set. Then the lowest-index
// maskable source, unless NMI-active or disable is set. Nothing is taken
// while hold is high. Also produces the vector of the maskable winner.
module irq_arbiter #(
    parameter int          N_MI    = 6,
    parameter logic [31:0] MI_BASE = 32'h80,
    parameter logic [31:0] MI_STEP = 32'h10
) (
    input  logic            nmi_pend,
    input  logic [N_MI-1:0] mi_pend,
    input  logic            np_bit,
    input  logic            id_bit,
    input  logic            hold,
    output logic            nmi_take,
    output logic            mi_any,
    output logic [N_MI-1:0] mi_take,
    output logic [31:0]     mi_vec
);
    localparam int IDX_W = (N_MI > 1) ? $clog2(N_MI) : 1;

    logic [IDX_W-1:0] win_idx;

    // Gate the NMI by its in-progress bit and the hold input.
    always_comb begin
        nmi_take = nmi_pend & ~np_bit & ~hold;
        mi_any   = (|mi_pend) & ~np_bit & ~id_bit & ~hold & ~nmi_take;
    end

    // Priority search: scanning downward leaves the lowest set index.
    always_comb begin
        win_idx = '0;
        for (int i = N_MI - 1; i >= 0; i--) begin
            if (mi_pend[i]) win_idx = IDX_W'(i);
        end
    end

    // One-hot acceptance and the vector of the winning source.
    always_comb begin
        mi_take = '0;
        if (mi_any) mi_take[win_idx] = 1'b1;
        mi_vec = MI_BASE + MI_STEP * 32'(win_idx);
    end

endmodule

// File: rtl/irq_ctx_regs.sv
// Module: PSW copy, cause register, save registers and the redirect
// output. Order of precedence: reset request, return, PSW load, NMI
// entry, maskable entry. Assumes the arbiter takes nothing while a
// reset, return or PSW load is present.
module irq_ctx_regs
    import irq_entry_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rst_req,
    input  logic            ret_strobe,
    input  logic            ret_sel,
    input  logic            psw_wr_en,
    input  logic [XLEN-1:0] psw_wr_data,
    input  logic [XLEN-1:0] cur_pc,
    input  logic            nmi_take,
    input  logic            mi_any,
    input  logic [XLEN-1:0] mi_vec,
    output logic            redirect,
    output logic [XLEN-1:0] redirect_pc,
    output logic [1:0]      redirect_kind,
    output logic [XLEN-1:0] psw,
    output logic [XLEN-1:0] ecr,
    output logic [XLEN-1:0] nmi_save_pc,
    output logic [XLEN-1:0] nmi_save_psw,
    output logic [XLEN-1:0] mi_save_pc,
    output logic [XLEN-1:0] mi_save_psw
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] psw_nmi_entry;
    logic [XLEN-1:0] psw_mi_entry;

    // Build the PSW values written on entry.
    always_comb begin
        psw_nmi_entry             = psw;
        psw_nmi_entry[PSW_NP_BIT] = 1'b1;
        psw_nmi_entry[PSW_ID_BIT] = 1'b1;
        psw_nmi_entry[PSW_EP_BIT] = 1'b0;
        psw_mi_entry              = psw;
        psw_mi_entry[PSW_ID_BIT]  = 1'b1;
        psw_mi_entry[PSW_EP_BIT]  = 1'b0;
    end

    // Apply reset, return, PSW load or entry to the architectural state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect      <= 1'b0;
            redirect_pc   <= '0;
            redirect_kind <= RK_RESET;
            psw           <= PSW_AT_RESET;
            ecr           <= '0;
            nmi_save_pc   <= '0;
            nmi_save_psw  <= '0;
            mi_save_pc    <= '0;
            mi_save_psw   <= '0;
        end else begin
            redirect <= 1'b0;
            if (rst_req) begin
                redirect      <= 1'b1;
                redirect_pc   <= '0;
                redirect_kind <= RK_RESET;
                psw           <= PSW_AT_RESET;
                ecr           <= '0;
            end else if (ret_strobe) begin
                redirect      <= 1'b1;
                redirect_kind <= RK_RETURN;
                if (ret_sel) begin
                    redirect_pc <= nmi_save_pc;
                    psw         <= nmi_save_psw;
                end else begin
                    redirect_pc <= mi_save_pc;
                    psw         <= mi_save_psw;
                end
            end else if (psw_wr_en) begin
                psw <= psw_wr_data;
            end else if (nmi_take) begin
                redirect          <= 1'b1;
                redirect_pc       <= NMI_TARGET;
                redirect_kind     <= RK_NMI;
                nmi_save_pc       <= cur_pc;
                nmi_save_psw      <= psw;
                psw               <= psw_nmi_entry;
                ecr[XLEN-1:HALF]  <= NMI_TARGET[HALF-1:0];
            end else if (mi_any) begin
                redirect          <= 1'b1;
                redirect_pc       <= mi_vec;
                redirect_kind     <= RK_MASK;
                mi_save_pc        <= cur_pc;
                mi_save_psw       <= psw;
                psw               <= psw_mi_entry;
                ecr[HALF-1:0]     <= mi_vec[HALF-1:0];
            end
        end
    end

endmodule

// File: rtl/irq_entry_ctrl.sv
// Module: top of the interrupt entry controller. Latches the requests,
// arbitrates them against the PSW mask bits and updates the context
// registers. A redirect appears one edge after the request is latched.
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int          N_MI    = 6,
    parameter logic [31:0] MI_BASE = 32'h80,
    parameter logic [31:0] MI_STEP = 32'h10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rst_req,
    input  logic            nmi_req,
    input  logic [N_MI-1:0] mi_req,
    input  logic [31:0]     cur_pc,
    input  logic            ret_strobe,
    input  logic            ret_sel,
    input  logic            psw_wr_en,
    input  logic [31:0]     psw_wr_data,
    output logic            redirect,
    output logic [31:0]     redirect_pc,
    output logic [1:0]      redirect_kind,
    output logic [31:0]     psw,
    output logic [31:0]     ecr,
    output logic [31:0]     nmi_save_pc,
    output logic [31:0]     nmi_save_psw,
    output logic [31:0]     mi_save_pc,
    output logic [31:0]     mi_save_psw
);
    logic            nmi_pend;
    logic [N_MI-1:0] mi_pend;
    logic            nmi_take;
    logic            mi_any;
    logic [N_MI-1:0] mi_take;
    logic [31:0]     mi_vec;
    logic            hold;

    // Nothing is accepted while reset, return or PSW load is in progress.
    always_comb hold = rst_req | ret_strobe | psw_wr_en;

    irq_pend_latch #(.N_MI(N_MI)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (rst_req),
        .nmi_req  (nmi_req),
        .mi_req   (mi_req),
        .nmi_take (nmi_take),
        .mi_take  (mi_take),
        .nmi_pend (nmi_pend),
        .mi_pend  (mi_pend)
    );

    irq_arbiter #(.N_MI(N_MI), .MI_BASE(MI_BASE), .MI_STEP(MI_STEP)) u_arb (
        .nmi_pend (nmi_pend),
        .mi_pend  (mi_pend),
        .np_bit   (psw[PSW_NP_BIT]),
        .id_bit   (psw[PSW_ID_BIT]),
        .hold     (hold),
        .nmi_take (nmi_take),
        .mi_any   (mi_any),
        .mi_take  (mi_take),
        .mi_vec   (mi_vec)
    );

    irq_ctx_regs u_ctx (
        .clk           (clk),
        .rst_n         (rst_n),
        .rst_req       (rst_req),
        .ret_strobe    (ret_strobe),
        .ret_sel       (ret_sel),
        .psw_wr_en     (psw_wr_en),
        .psw_wr_data   (psw_wr_data),
        .cur_pc        (cur_pc),
        .nmi_take      (nmi_take),
        .mi_any        (mi_any),
        .mi_vec        (mi_vec),
        .redirect      (redirect),
        .redirect_pc   (redirect_pc),
        .redirect_kind (redirect_kind),
        .psw           (psw),
        .ecr           (ecr),
        .nmi_save_pc   (nmi_save_pc),
        .nmi_save_psw  (nmi_save_psw),
        .mi_save_pc    (mi_save_pc),
        .mi_save_psw   (mi_save_psw)
    );

endmodule

// File: rtl/irq_entry_ctrl_chk.sv
// Checker: cycle-by-cycle properties of the entry controller, seen only
// at its ports. Attached to every instance with the bind at the bottom.
module irq_entry_ctrl_chk #(
    parameter int N_MI = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rst_req,
    input logic            nmi_req,
    input logic [N_MI-1:0] mi_req,
    input logic [31:0]     cur_pc,
    input logic            ret_strobe,
    input logic            ret_sel,
    input logic            psw_wr_en,
    input logic [31:0]     psw_wr_data,
    input logic            redirect,
    input logic [31:0]     redirect_pc,
    input logic [1:0]      redirect_kind,
    input logic [31:0]     psw,
    input logic [31:0]     ecr,
    input logic [31:0]     nmi_save_pc,
    input logic [31:0]     nmi_save_psw,
    input logic [31:0]     mi_save_pc,
    input logic [31:0]     mi_save_psw
);
    localparam logic [31:0] TOP_VEC = 32'h80 + 32'h10 * 32'(N_MI - 1);

    a_r1_reset_req: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (redirect && redirect_kind == 2'd0 && redirect_pc == 32'h0
                     && psw == 32'h20 && ecr == 32'h0));

    a_r2_nmi_not_nested: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && redirect_kind == 2'd1) |-> !$past(psw[7]));

    a_r3_nmi_save: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && redirect_kind == 2'd1) |->
            (nmi_save_pc == $past(cur_pc) && nmi_save_psw == $past(psw)
             && $stable(mi_save_pc) && $stable(mi_save_psw)));

    a_r4_nmi_psw: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && redirect_kind == 2'd1) |->
            (redirect_pc == 32'h10 && psw[7] && psw[5] && !psw[6]));

    a_r5_nmi_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && redirect_kind == 2'd1) |->
            (ecr[31:16] == 16'h0010 && ecr[15:0] == $past(ecr[15:0])));

    a_r6_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && redirect_kind == 2'd2) |-> (!$past(psw[7]) && !$past(psw[5])));

    a_r7_mask_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && redirect_kind == 2'd2) |->
            (psw[5] && !psw[6] && mi_save_pc == $past(cur_pc)
             && mi_save_psw == $past(psw) && ecr[31:16] == $past(ecr[31:16])));

    a_r8_mask_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && redirect_kind == 2'd2) |->
            (redirect_pc[3:0] == 4'h0 && redirect_pc >= 32'h80
             && redirect_pc <= TOP_VEC && ecr[15:0] == redirect_pc[15:0]));

    a_r11_return: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_strobe && !rst_req) |=>
            (redirect && redirect_kind == 2'd3
             && redirect_pc == ($past(ret_sel) ? $past(nmi_save_pc) : $past(mi_save_pc))
             && psw == ($past(ret_sel) ? $past(nmi_save_psw) : $past(mi_save_psw))));

    a_r13_psw_load: assert property (@(posedge clk) disable iff (!rst_n)
        (psw_wr_en && !rst_req && !ret_strobe) |=> (!redirect && psw == $past(psw_wr_data)));

endmodule

bind irq_entry_ctrl irq_entry_ctrl_chk #(.N_MI(N_MI)) u_chk (.*);

// File: tb/irq_entry_ctrl_test.sv
// Bench: sweeps every maskable source, every combination of sources and
// the NMI pending cases. Expected values are computed from the requirements.
module irq_entry_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rst_req = 1'b0;
    logic          nmi_req = 1'b0;
    logic [NS-1:0] mi_req = '0;
    logic [31:0]   cur_pc = '0;
    logic          ret_strobe = 1'b0;
    logic          ret_sel = 1'b0;
    logic          psw_wr_en = 1'b0;
    logic [31:0]   psw_wr_data = '0;
    logic          redirect;
    logic [31:0]   redirect_pc;
    logic [1:0]    redirect_kind;
    logic [31:0]   psw, ecr, nmi_save_pc, nmi_save_psw, mi_save_pc, mi_save_psw;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    irq_entry_ctrl uut (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk_redir(input string tag, input logic [1:0] kind, input logic [31:0] pc);
        chk({tag, " redirect"}, 32'(redirect), 32'd1);
        chk({tag, " kind"}, 32'(redirect_kind), 32'(kind));
        chk({tag, " pc"}, redirect_pc, pc);
    endtask

    task automatic chk_quiet(input string tag);
        chk({tag, " no redirect"}, 32'(redirect), 32'd0);
    endtask

    // R11: return strobe, then check target and restored PSW
    task automatic do_ret(input logic sel, input logic [31:0] pc, input logic [31:0] pw);
        ret_strobe = 1'b1;
        ret_sel = sel;
        step();
        ret_strobe = 1'b0;
        chk_redir("R11 return", 2'd3, pc);
        chk("R11 restored psw", psw, pw);
    endtask

    // R13: direct PSW load
    task automatic do_wr(input logic [31:0] v);
        psw_wr_en = 1'b1;
        psw_wr_data = v;
        step();
        psw_wr_en = 1'b0;
        chk("R13 psw load", psw, v);
        chk_quiet("R13");
    endtask

    // One-cycle request pulse; returns at the cycle the redirect is visible (R12)
    task automatic pulse(input logic n, input logic [NS-1:0] m);
        nmi_req = n;
        mi_req = m;
        step();
        nmi_req = 1'b0;
        mi_req = '0;
        step();
    endtask

    function automatic logic [31:0] vec_of(input int i);
        return 32'h80 + 32'h10 * 32'(i);
    endfunction

    initial begin
        logic [31:0] lo_code;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: state after reset
        chk("R1 reset psw", psw, 32'h20);
        chk("R1 reset ecr", ecr, 32'h0);
        chk_quiet("R1 reset");

        do_wr(32'h0);

        // R7 R8 R12: each source alone, with and without EP set beforehand
        for (int i = 0; i < NS; i++) begin
            logic [31:0] pw;
            pw = (i % 2 == 0) ? 32'h40 : 32'h0;
            do_wr(pw);
            cur_pc = 32'h1000 + 32'(i * 4);
            pulse(1'b0, NS'(1 << i));
            chk_redir("R8 vector", 2'd2, vec_of(i));
            chk("R7 psw ID set EP clear", psw, 32'h20);
            chk("R8 cause code", ecr, vec_of(i));
            chk("R7 save pc", mi_save_pc, cur_pc);
            chk("R7 save psw", mi_save_psw, pw);
            step();
            chk_quiet("R12 single cycle");
            do_ret(1'b0, cur_pc, pw);
        end

        // R10 R6: every combination of sources, drained in priority order
        do_wr(32'h0);
        cur_pc = 32'h3000;
        for (int m = 1; m < (1 << NS); m++) begin
            logic [NS-1:0] rem;
            rem = NS'(m);
            pulse(1'b0, NS'(m));
            while (rem != '0) begin
                int w;
                w = 0;
                for (int b = NS - 1; b >= 0; b--) if (rem[b]) w = b;
                chk_redir("R10 priority", 2'd2, vec_of(w));
                rem[w] = 1'b0;
                step();
                chk_quiet("R6 held while disabled");
                do_ret(1'b0, 32'h3000, 32'h0);
                step();
            end
            chk_quiet("R10 latches drained");
        end
        lo_code = vec_of(NS - 1);

        // R4 R5 R3: NMI entry from PSW 0
        cur_pc = 32'h2000;
        pulse(1'b1, '0);
        chk_redir("R4 nmi", 2'd1, 32'h10);
        chk("R4 nmi psw", psw, 32'hA0);
        chk("R5 nmi cause", ecr, {16'h0010, lo_code[15:0]});
        chk("R3 nmi save pc", nmi_save_pc, 32'h2000);
        chk("R3 nmi save psw", nmi_save_psw, 32'h0);
        chk("R3 maskable save untouched", mi_save_pc, 32'h3000);

        // R2 R6: more NMIs and a maskable request while NMI active
        pulse(1'b1, '0);
        chk_quiet("R2 nmi held");
        pulse(1'b1, 6'b000100);
        chk_quiet("R6 blocked by NP");
        step();
        chk_quiet("R2 still held");
        do_ret(1'b1, 32'h2000, 32'h0);
        step();
        chk_redir("R2 held nmi delivered", 2'd1, 32'h10);
        step();
        chk_quiet("R2 no second nmi yet");
        do_ret(1'b1, 32'h2000, 32'h0);
        step();
        chk_redir("R10 maskable after nmi", 2'd2, 32'hA0);
        chk("R7 cause halves", ecr, 32'h001000A0);
        step();
        chk_quiet("R2 merged nmis");
        do_ret(1'b0, 32'h2000, 32'h0);
        step();
        chk_quiet("R2 nothing left");

        // R9: NMI arriving during NMI acceptance stays pending
        nmi_req = 1'b1;
        step();
        step();
        nmi_req = 1'b0;
        chk_redir("R9 first nmi", 2'd1, 32'h10);
        step();
        chk_quiet("R9 second waits");
        do_ret(1'b1, 32'h2000, 32'h0);
        step();
        chk_redir("R9 second nmi", 2'd1, 32'h10);
        do_ret(1'b1, 32'h2000, 32'h0);
        step();
        chk_quiet("R9 only two");

        // R10: NMI and maskable in the same cycle
        pulse(1'b1, 6'b001000);
        chk_redir("R10 nmi beats maskable", 2'd1, 32'h10);
        do_ret(1'b1, 32'h2000, 32'h0);
        step();
        chk_redir("R10 maskable follows", 2'd2, 32'hB0);
        do_ret(1'b0, 32'h2000, 32'h0);

        // R3: NMI inside a maskable handler keeps both contexts
        cur_pc = 32'h4000;
        pulse(1'b0, 6'b000001);
        chk_redir("R3 outer maskable", 2'd2, 32'h80);
        cur_pc = 32'h5000;
        pulse(1'b1, '0);
        chk_redir("R3 nested nmi", 2'd1, 32'h10);
        chk("R3 nested psw", psw, 32'hA0);
        chk("R3 nmi save psw", nmi_save_psw, 32'h20);
        chk("R3 maskable save kept", mi_save_pc, 32'h4000);
        do_ret(1'b1, 32'h5000, 32'h20);
        do_ret(1'b0, 32'h4000, 32'h0);

        // R1: reset request discards held requests
        do_wr(32'h20);
        mi_req = '1;
        step();
        mi_req = '0;
        rst_req = 1'b1;
        nmi_req = 1'b1;
        step();
        rst_req = 1'b0;
        nmi_req = 1'b0;
        chk_redir("R1 reset request", 2'd0, 32'h0);
        chk("R1 reset request psw", psw, 32'h20);
        chk("R1 reset request ecr", ecr, 32'h0);
        do_ret(1'b0, 32'h4000, 32'h0);
        for (int k = 0; k < 3; k++) begin
            step();
            chk_quiet("R1 pending discarded");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule